// File: doc/BRIEF.md
# Per-Block Flash Lock Controller

This block decides, for each access to a flash array divided into uniform 64 KB blocks, whether the access may go ahead. Each block can be erased or programmed on its own. Each block has its own three-bit lock register with three flags: a write lock, a read lock and a sticky lock-down flag. The block also takes two hardware protection inputs. One guards the topmost block. The other guards every block below it.

The array controller presents an access: a kind (read, program or erase), a byte address, and the byte the array produced for a read. In the same cycle the block answers with a grant or a deny. It also returns the read byte, or 0xFF when the target block is read-locked. Software sets the lock registers through a small register port with a write strobe, a block index and three data bits. The register selected by the index is always visible on the read-back output.

Top module: `flash_lock_ctrl`

## Requirements
- R1: The block index is taken from address bits 18:16 (eight blocks of 64 KB in a 512 KB array), and the block with index 7 is the top block.
- R2: Reset clears every lock register to 3'b000.
- R3: A register write with `reg_we` high stores `reg_wdata` into the register chosen by `reg_idx` on the next clock edge. Bit 0 is write lock, bit 1 is lock-down and bit 2 is read lock. `reg_rdata` shows, without delay, the register chosen by `reg_idx`.
- R4: Once the lock-down bit of a block is set, register writes to that block change none of its three bits until reset.
- R5: A read (kind 2'b00) of a read-locked block is denied, and `rd_data` is 8'hFF.
- R6: A read of a block without read lock is granted and passes `arr_rdata` to `rd_data`, whatever the write lock and the protection inputs are.
- R7: A program (kind 2'b01) or erase (kind 2'b10) of a write-locked block is denied.
- R8: With `top_prot` high, program and erase of the top block are denied, and other blocks are not affected by this input.
- R9: With `rest_prot` high, program and erase of every block except the top block are denied, and the top block is not affected by this input.
- R10: With `acc_valid` high exactly one of `acc_grant` and `acc_deny` is high. With `acc_valid` low both are low. A write is granted only when no protection that applies to it is active.
- R11: The reserved access kind 2'b11 is always denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| top_prot | input | 1 | Protects the top block from program and erase |
| rest_prot | input | 1 | Protects all non-top blocks from program and erase |
| reg_we | input | 1 | Lock register write strobe |
| reg_idx | input | 3 | Lock register select for write and read-back |
| reg_wdata | input | 3 | Lock register write data (bit0 write lock, bit1 lock-down, bit2 read lock) |
| reg_rdata | output | 3 | Contents of the selected lock register |
| acc_valid | input | 1 | An access is presented |
| acc_kind | input | 2 | 00 read, 01 program, 10 erase, 11 reserved |
| acc_addr | input | 19 | Byte address of the access |
| arr_rdata | input | 8 | Byte read from the array |
| acc_grant | output | 1 | Access allowed |
| acc_deny | output | 1 | Access refused |
| rd_data | output | 8 | Read byte, forced to 0xFF for read-locked blocks |

## Verification
Each access kind is applied to blocks whose protection differs in only one source. The source is either a register bit or one of the two pins. A deny can therefore be traced to that source alone. Addresses at the edges of block 6 and block 7 show that the top-block decision follows bits 18:16 and not the lower address bits. Reads are tried with write lock and both pins active, to show that these write protections leave reads alone. Lock-down is tested with writes that try to clear it and writes that try to set more bits, and then with a reset.

// File: rtl/flock_pkg.sv
package flock_pkg;

  localparam int LOCK_W = 3;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_PROG  = 2'b01,
    ACC_ERASE = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  // bit0 write lock, bit1 lock-down, bit2 read lock
  typedef struct packed {
    logic rlock;
    logic ldown;
    logic wlock;
  } lock_t;

  function automatic logic is_modify(acc_kind_e k);
    return (k == ACC_PROG) || (k == ACC_ERASE);
  endfunction

  // Which hardware pin applies depends only on whether the block is the top one
  function automatic logic pin_blocks(logic top, logic top_p, logic rest_p);
    return top ? top_p : rest_p;
  endfunction

  function automatic logic write_refused(lock_t lk, logic pin_hit);
    return lk.wlock | pin_hit;
  endfunction

endpackage

// File: rtl/lock_bank.sv
module lock_bank
  import flock_pkg::*;
#(
  parameter int NUM_BLK = 8,
  localparam int IDX_W = $clog2(NUM_BLK)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  lock_t                      wr_data,
  input  logic [IDX_W-1:0]           rd_idx,
  output lock_t                      rd_data,
  input  logic [IDX_W-1:0]           acc_idx,
  output lock_t                      acc_lock,
  output logic [NUM_BLK*LOCK_W-1:0]  locks_flat,
  output logic                       wr_frozen
);

  lock_t regs [NUM_BLK];

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[g] <= '0;
      end else if (sel && !regs[g].ldown) begin
        regs[g] <= wr_data;
      end
    end

    assign locks_flat[g*LOCK_W +: LOCK_W] = regs[g];
  end

  assign rd_data   = regs[rd_idx];
  assign acc_lock  = regs[acc_idx];
  assign wr_frozen = wr_en && regs[wr_idx].ldown;

endmodule

// File: rtl/access_gate.sv
module access_gate
  import flock_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              valid,
  input  acc_kind_e         kind,
  input  lock_t             lk,
  input  logic              is_top,
  input  logic              top_prot,
  input  logic              rest_prot,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              grant,
  output logic              deny,
  output logic [DATA_W-1:0] rd_data,
  output logic              rlock_hit,
  output logic              wlock_hit,
  output logic              pin_hit
);

  logic refused;

  assign pin_hit   = is_modify(kind) && pin_blocks(is_top, top_prot, rest_prot);
  assign wlock_hit = is_modify(kind) && lk.wlock;
  assign rlock_hit = (kind == ACC_READ) && lk.rlock;

  always_comb begin
    unique case (kind)
      ACC_READ:            refused = lk.rlock;
      ACC_PROG, ACC_ERASE: refused = write_refused(lk, pin_blocks(is_top, top_prot, rest_prot));
      default:             refused = 1'b1;
    endcase
  end

  assign grant   = valid && !refused;
  assign deny    = valid && refused;
  assign rd_data = rlock_hit ? {DATA_W{1'b1}} : arr_rdata;

endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl
  import flock_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int BLK_SHIFT = 16,
  parameter int DATA_W    = 8,
  localparam int IDX_W    = ADDR_W - BLK_SHIFT,
  localparam int NUM_BLK  = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              top_prot,
  input  logic              rest_prot,
  input  logic              reg_we,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [2:0]        reg_wdata,
  output logic [2:0]        reg_rdata,
  input  logic              acc_valid,
  input  logic [1:0]        acc_kind,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              acc_grant,
  output logic              acc_deny,
  output logic [DATA_W-1:0] rd_data
);

  logic [IDX_W-1:0]          blk_idx;
  logic                      is_top;
  lock_t                     acc_lock;
  lock_t                     rb_lock;
  logic [NUM_BLK*LOCK_W-1:0] locks_flat;
  logic                      wr_frozen;
  logic                      rlock_hit;
  logic                      wlock_hit;
  logic                      pin_hit;

  assign blk_idx   = acc_addr[BLK_SHIFT +: IDX_W];
  assign is_top    = (blk_idx == IDX_W'(NUM_BLK - 1));
  assign reg_rdata = rb_lock;

  lock_bank #(.NUM_BLK(NUM_BLK)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_we),
    .wr_idx     (reg_idx),
    .wr_data    (lock_t'(reg_wdata)),
    .rd_idx     (reg_idx),
    .rd_data    (rb_lock),
    .acc_idx    (blk_idx),
    .acc_lock   (acc_lock),
    .locks_flat (locks_flat),
    .wr_frozen  (wr_frozen)
  );

  access_gate #(.DATA_W(DATA_W)) u_gate (
    .valid     (acc_valid),
    .kind      (acc_kind_e'(acc_kind)),
    .lk        (acc_lock),
    .is_top    (is_top),
    .top_prot  (top_prot),
    .rest_prot (rest_prot),
    .arr_rdata (arr_rdata),
    .grant     (acc_grant),
    .deny      (acc_deny),
    .rd_data   (rd_data),
    .rlock_hit (rlock_hit),
    .wlock_hit (wlock_hit),
    .pin_hit   (pin_hit)
  );

endmodule

// File: rtl/flock_checker.sv
module flock_checker #(
  parameter int NUM_BLK = 8,
  parameter int IDX_W   = 3,
  parameter int DATA_W  = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  top_prot,
  input logic                  rest_prot,
  input logic                  acc_valid,
  input logic [1:0]            acc_kind,
  input logic                  is_top,
  input logic                  acc_grant,
  input logic                  acc_deny,
  input logic [DATA_W-1:0]     rd_data,
  input logic                  rlock_hit,
  input logic                  wlock_hit,
  input logic [NUM_BLK*3-1:0]  locks_flat
);

  logic modify;
  assign modify = acc_valid && (acc_kind == 2'b01 || acc_kind == 2'b10);

  assert_one_answer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> $countones({acc_grant, acc_deny}) == 1);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !acc_grant && !acc_deny);

  assert_top_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    modify && is_top && top_prot |-> acc_deny);

  assert_rest_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    modify && !is_top && rest_prot |-> acc_deny);

  assert_wlock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && wlock_hit |-> acc_deny);

  assert_rlock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && rlock_hit |-> acc_deny && rd_data == {DATA_W{1'b1}});

  assert_rsvd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_kind == 2'b11 |-> acc_deny);

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_sticky
    assert_ldown_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      locks_flat[g*3+1] |=> $stable(locks_flat[g*3 +: 3]));
  end

endmodule

bind flash_lock_ctrl flock_checker #(
  .NUM_BLK (NUM_BLK),
  .IDX_W   (IDX_W),
  .DATA_W  (DATA_W)
) u_flock_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .top_prot   (top_prot),
  .rest_prot  (rest_prot),
  .acc_valid  (acc_valid),
  .acc_kind   (acc_kind),
  .is_top     (is_top),
  .acc_grant  (acc_grant),
  .acc_deny   (acc_deny),
  .rd_data    (rd_data),
  .rlock_hit  (rlock_hit),
  .wlock_hit  (wlock_hit),
  .locks_flat (locks_flat)
);

// File: tb/tb_flash_lock_ctrl.sv
module tb_flash_lock_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        top_prot = 1'b0;
  logic        rest_prot = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [2:0]  reg_wdata = '0;
  logic [2:0]  reg_rdata;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_kind = '0;
  logic [18:0] acc_addr = '0;
  logic [7:0]  arr_rdata = '0;
  logic        acc_grant;
  logic        acc_deny;
  logic [7:0]  rd_data;

  int checks = 0;
  int errors = 0;

  localparam logic [1:0] K_RD = 2'b00, K_PG = 2'b01, K_ER = 2'b10, K_RS = 2'b11;

  always #5 clk = ~clk;

  flash_lock_ctrl dut (
    .clk(clk), .rst_n(rst_n), .top_prot(top_prot), .rest_prot(rest_prot),
    .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_addr(acc_addr),
    .arr_rdata(arr_rdata), .acc_grant(acc_grant), .acc_deny(acc_deny), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] idx, input logic [2:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic peek_reg(input string req, input logic [2:0] idx, input logic [2:0] exp);
    reg_idx = idx;
    #1;
    chk(req, 32'(reg_rdata), 32'(exp));
  endtask

  // Presents an access; expectation: grant flag and returned byte
  task automatic access(input string req, input logic [1:0] k, input logic [18:0] a,
                        input logic exp_grant, input logic [7:0] exp_data);
    @(negedge clk);
    acc_valid = 1'b1; acc_kind = k; acc_addr = a;
    #1;
    chk(req, {30'd0, acc_grant, acc_deny}, {30'd0, exp_grant, ~exp_grant});
    if (k == K_RD) chk(req, 32'(rd_data), 32'(exp_data));
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    for (int i = 0; i < 8; i++) peek_reg("R2", 3'(i), 3'b000);
  endtask

  task automatic t_regs();
    wr_reg(3'd3, 3'b101);
    peek_reg("R3", 3'd3, 3'b101);
    peek_reg("R3", 3'd2, 3'b000);
    wr_reg(3'd3, 3'b000);
    peek_reg("R3", 3'd3, 3'b000);
  endtask

  task automatic t_reads();
    arr_rdata = 8'hA5;
    access("R6", K_RD, 19'h2_1234, 1'b1, 8'hA5);
    wr_reg(3'd2, 3'b100);
    access("R5", K_RD, 19'h2_1234, 1'b0, 8'hFF);
    access("R5", K_RD, 19'h3_0000, 1'b1, 8'hA5);
    wr_reg(3'd4, 3'b001);
    top_prot = 1'b1; rest_prot = 1'b1;
    arr_rdata = 8'h3C;
    access("R6", K_RD, 19'h4_0010, 1'b1, 8'h3C);
    access("R6", K_RD, 19'h7_0010, 1'b1, 8'h3C);
    top_prot = 1'b0; rest_prot = 1'b0;
    wr_reg(3'd2, 3'b000);
    wr_reg(3'd4, 3'b000);
  endtask

  task automatic t_wlock();
    wr_reg(3'd4, 3'b001);
    access("R7", K_PG, 19'h4_0000, 1'b0, 8'h00);
    access("R7", K_ER, 19'h4_FFFF, 1'b0, 8'h00);
    access("R7", K_PG, 19'h5_0000, 1'b1, 8'h00);
    wr_reg(3'd4, 3'b000);
    access("R10", K_ER, 19'h4_0000, 1'b1, 8'h00);
  endtask

  task automatic t_pins();
    top_prot = 1'b1;
    access("R8", K_PG, 19'h7_0000, 1'b0, 8'h00);
    access("R8", K_ER, 19'h7_FFFF, 1'b0, 8'h00);
    access("R8", K_PG, 19'h0_0000, 1'b1, 8'h00);
    access("R1", K_ER, 19'h6_FFFF, 1'b1, 8'h00);
    top_prot = 1'b0; rest_prot = 1'b1;
    access("R9", K_PG, 19'h0_0000, 1'b0, 8'h00);
    access("R9", K_ER, 19'h6_FFFF, 1'b0, 8'h00);
    access("R9", K_PG, 19'h7_0000, 1'b1, 8'h00);
    rest_prot = 1'b0;
    wr_reg(3'd7, 3'b001);
    access("R10", K_PG, 19'h7_0000, 1'b0, 8'h00);
    wr_reg(3'd7, 3'b000);
  endtask

  task automatic t_lockdown();
    wr_reg(3'd1, 3'b011);
    peek_reg("R4", 3'd1, 3'b011);
    wr_reg(3'd1, 3'b000);
    peek_reg("R4", 3'd1, 3'b011);
    wr_reg(3'd1, 3'b111);
    peek_reg("R4", 3'd1, 3'b011);
    access("R4", K_PG, 19'h1_0000, 1'b0, 8'h00);
    do_reset();
    peek_reg("R2", 3'd1, 3'b000);
    access("R4", K_PG, 19'h1_0000, 1'b1, 8'h00);
  endtask

  task automatic t_misc();
    acc_valid = 1'b0; acc_kind = K_PG; acc_addr = 19'h0;
    @(negedge clk); #1;
    chk("R10", {30'd0, acc_grant, acc_deny}, 32'd0);
    access("R11", K_RS, 19'h0_0000, 1'b0, 8'h00);
    access("R11", K_RS, 19'h7_0000, 1'b0, 8'h00);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_reads();
    t_wlock();
    t_pins();
    t_lockdown();
    t_misc();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule